// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Data Cache

This block follows the block misses that a non-blocking data cache has in flight. It has a small set of tracking entries. Each entry holds one missing block: its block address, a prefetch flag, a flag that marks the request as issued, a mask of the sub-blocks that have already returned, a buffer for each sub-block, and a short list of the loads and stores waiting on that block. A cache miss goes into the tracker. If an entry already covers the same block, the access joins that entry as a waiter and no further memory traffic is made. If no entry covers it, a free entry is claimed and one request goes to the next memory level. If the access cannot be placed, the requester is told to stall.

Refill data comes back one sub-block per beat, tagged with the entry index and the sub-block index. Each waiter that needs the sub-block of that beat gets the data on its own forward lane and is released. Once every sub-block has arrived, the whole block is sent out on a fill port for the cache arrays and the entry is freed. An access that finds its sub-block already buffered gets its data at once through a separate forward lane and does not take a waiter place.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is live. `req_stall`, `mem_req_valid`, `fwd_valid` and `fill_valid` are all low while no request or refill is presented.
- R2: A request whose block matches no live entry, with a free entry available, claims the lowest-numbered free entry. In the same cycle it raises `mem_req_valid` with `mem_req_blk` equal to the request block and `mem_req_id` equal to the entry index.
- R3: A demand request whose block matches a live entry, and whose sub-block (`req_off[3:2]`) is not buffered, is added as a waiter. It does not stall and raises no memory request.
- R4: `req_stall` is raised in the request cycle, and no memory request is made, in two cases: a non-matching request finds all 4 entries live, or a matching demand request finds all 4 waiter places of that entry occupied.
- R5: One cycle after a refill beat, lane i of `fwd_valid` (i < 4) is high for every waiter place i of that entry whose sub-block equals the beat's sub-block. That lane carries the beat data on `fwd_data` and the waiter's {store, size[1:0], offset[3:0], dest[5:0]} on `fwd_info`. Each lane is 13 bits wide with lane i at bits i*13. The waiter is released.
- R6: One cycle after the beat that completes the sub-block mask, `fill_valid` is high with the entry's block address on `fill_blk` and sub-block k on `fill_data[k*32 +: 32]`. The entry is then free and may be claimed again.
- R7: A demand request that matches an entry whose needed sub-block is already buffered is answered one cycle later on lane 4 with the buffered data and its own info. It takes no waiter place.
- R8: A demand request that matches the entry and sub-block of a refill beat in the same cycle is answered one cycle later on lane 4 with that beat's data.
- R9: A request that matches the entry whose final sub-block arrives in the same cycle is stalled.
- R10: A prefetch request (`req_pref`) claims an entry with its prefetch flag set but takes no waiter place. A prefetch that matches a live entry is absorbed without a stall. A demand request that merges into the entry clears the flag. `fill_pref` shows the flag with the fill.
- R11: A merged waiter takes the lowest-numbered free waiter place of its entry. Waiter places released in the same cycle become usable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_blk | input | 28 | Block address of the miss |
| req_pref | input | 1 | Request is a prefetch |
| req_store | input | 1 | Access is a store |
| req_size | input | 2 | Access size code |
| req_off | input | 4 | Byte offset in block; bits [3:2] select the sub-block |
| req_dest | input | 6 | Destination register or store-buffer index |
| req_stall | output | 1 | Request cannot be accepted this cycle |
| mem_req_valid | output | 1 | New block request to the next level |
| mem_req_blk | output | 28 | Block address of the new request |
| mem_req_id | output | 2 | Entry index used to tag refill beats |
| rfl_valid | input | 1 | Refill beat present |
| rfl_id | input | 2 | Entry index of the beat |
| rfl_sub | input | 2 | Sub-block index of the beat |
| rfl_data | input | 32 | Sub-block data |
| fwd_valid | output | 5 | Forward lane valids: lanes 0..3 waiter places, lane 4 direct answer |
| fwd_info | output | 65 | Per-lane {store, size, offset, dest} |
| fwd_data | output | 160 | Per-lane 32-bit data |
| fill_valid | output | 1 | Completed block ready for the cache |
| fill_blk | output | 28 | Block address of the fill |
| fill_data | output | 128 | Whole block, sub-block k at bits k*32 |
| fill_pref | output | 1 | Filled block was fetched only by prefetch |

## Verification
The stall decision and the memory request are combinational, so they are due in the request cycle itself. The bench drives inputs just after a falling edge and reads these two results 1 ns later. Forward lanes and fills pass through one register and are due after the next rising edge, so the bench reads them at the following falling edge, before it changes any input. Every expected lane mask, info word and fill block is built in the bench from the waiter list it placed and from a closed-form data pattern per entry and sub-block.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    parameter int ENT_N  = 4;
    parameter int SLOT_N = 4;
    parameter int SUB_N  = 4;
    parameter int SUB_W  = 32;
    parameter int BLK_W  = 28;
    parameter int DEST_W = 6;
    parameter int SIZE_W = 2;

    localparam int ENT_IW  = $clog2(ENT_N);
    localparam int SLOT_IW = $clog2(SLOT_N);
    localparam int SUB_IW  = $clog2(SUB_N);
    localparam int BYTE_IW = $clog2(SUB_W / 8);
    localparam int OFF_W   = SUB_IW + BYTE_IW;
    localparam int LANE_N  = SLOT_N + 1;
    localparam int LINE_W  = SUB_N * SUB_W;
    localparam int INFO_W  = 1 + SIZE_W + OFF_W + DEST_W;

    typedef struct packed {
        logic              store;
        logic [SIZE_W-1:0] size;
        logic [OFF_W-1:0]  off;
        logic [DEST_W-1:0] dest;
    } acc_t;

    typedef struct packed {
        logic valid;
        acc_t acc;
    } slot_t;

    typedef struct packed {
        logic                        valid;
        logic [BLK_W-1:0]            blk;
        logic                        pref;
        logic                        issued;
        logic [SUB_N-1:0]            arrived;
        logic [SUB_N-1:0][SUB_W-1:0] data;
        slot_t [SLOT_N-1:0]          slot;
    } entry_t;

    typedef struct packed {
        entry_t [ENT_N-1:0]           ent;
        logic [LANE_N-1:0]            fv;
        logic [LANE_N-1:0][INFO_W-1:0] fi;
        logic [LANE_N-1:0][SUB_W-1:0] fd;
        logic                         flv;
        logic [BLK_W-1:0]             flb;
        logic [LINE_W-1:0]            fld;
        logic                         flp;
    } state_t;
endpackage

// File: rtl/mshr_pick_first.sv
module mshr_pick_first #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |cand;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mshr_tag_match.sv
module mshr_tag_match #(
    parameter int N = 4,
    parameter int W = 28
) (
    input  logic [N-1:0]   live,
    input  logic [N*W-1:0] tags,
    input  logic [W-1:0]   probe,
    output logic [N-1:0]   hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = live[i] && (tags[i*W +: W] == probe);
    end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [BLK_W-1:0]         req_blk,
    input  logic                     req_pref,
    input  logic                     req_store,
    input  logic [SIZE_W-1:0]        req_size,
    input  logic [OFF_W-1:0]         req_off,
    input  logic [DEST_W-1:0]        req_dest,
    output logic                     req_stall,
    output logic                     mem_req_valid,
    output logic [BLK_W-1:0]         mem_req_blk,
    output logic [ENT_IW-1:0]        mem_req_id,
    input  logic                     rfl_valid,
    input  logic [ENT_IW-1:0]        rfl_id,
    input  logic [SUB_IW-1:0]        rfl_sub,
    input  logic [SUB_W-1:0]         rfl_data,
    output logic [LANE_N-1:0]        fwd_valid,
    output logic [LANE_N*INFO_W-1:0] fwd_info,
    output logic [LANE_N*SUB_W-1:0]  fwd_data,
    output logic                     fill_valid,
    output logic [BLK_W-1:0]         fill_blk,
    output logic [LINE_W-1:0]        fill_data,
    output logic                     fill_pref
);
    state_t s_q, s_d;

    logic [ENT_N-1:0]       live, hit_vec;
    logic [ENT_N*BLK_W-1:0] tag_flat;
    logic                   hit_any, free_any, slot_any;
    logic [ENT_IW-1:0]      hit_id, free_id;
    logic [SLOT_IW-1:0]     slot_id;
    logic [SLOT_N-1:0]      slot_open;
    logic [SUB_IW-1:0]      req_sub;
    logic                   rfl_live, rfl_last, rfl_same, closing;
    logic                   served, need_slot, take;
    acc_t                   acc;

    always_comb begin
        for (int e = 0; e < ENT_N; e++) begin
            live[e]                     = s_q.ent[e].valid;
            tag_flat[e*BLK_W +: BLK_W]  = s_q.ent[e].blk;
        end
        for (int s = 0; s < SLOT_N; s++) begin
            slot_open[s] = !s_q.ent[hit_id].slot[s].valid;
        end
    end

    mshr_tag_match #(.N(ENT_N), .W(BLK_W)) u_match (
        .live (live),
        .tags (tag_flat),
        .probe(req_blk),
        .hit  (hit_vec)
    );

    mshr_pick_first #(.N(ENT_N)) u_hit (
        .cand (hit_vec),
        .found(hit_any),
        .idx  (hit_id)
    );

    mshr_pick_first #(.N(ENT_N)) u_free (
        .cand (~live),
        .found(free_any),
        .idx  (free_id)
    );

    mshr_pick_first #(.N(SLOT_N)) u_slot (
        .cand (slot_open),
        .found(slot_any),
        .idx  (slot_id)
    );

    // Request decision: merge, answer directly, claim an entry, or stall.
    always_comb begin
        req_sub   = req_off[OFF_W-1 -: SUB_IW];
        acc       = '{store: req_store, size: req_size, off: req_off, dest: req_dest};
        rfl_live  = rfl_valid && s_q.ent[rfl_id].valid;
        rfl_last  = rfl_live &&
                    (&(s_q.ent[rfl_id].arrived | (SUB_N'(1) << rfl_sub)));
        rfl_same  = rfl_live && (rfl_id == hit_id);
        closing   = hit_any && rfl_same && rfl_last;
        served    = hit_any && !req_pref &&
                    (s_q.ent[hit_id].arrived[req_sub] || (rfl_same && rfl_sub == req_sub));
        need_slot = hit_any && !req_pref && !served;
        req_stall = req_valid &&
                    (hit_any ? (closing || (need_slot && !slot_any)) : !free_any);
        take          = req_valid && !req_stall;
        mem_req_valid = take && !hit_any;
        mem_req_blk   = req_blk;
        mem_req_id    = free_id;
    end

    // Next state.
    always_comb begin
        s_d     = s_q;
        s_d.fv  = '0;
        s_d.fi  = '0;
        s_d.fd  = '0;
        s_d.flv = 1'b0;

        if (rfl_live) begin
            s_d.ent[rfl_id].data[rfl_sub]    = rfl_data;
            s_d.ent[rfl_id].arrived[rfl_sub] = 1'b1;
            for (int s = 0; s < SLOT_N; s++) begin
                if (s_q.ent[rfl_id].slot[s].valid &&
                    s_q.ent[rfl_id].slot[s].acc.off[OFF_W-1 -: SUB_IW] == rfl_sub) begin
                    s_d.fv[s]                        = 1'b1;
                    s_d.fi[s]                        = s_q.ent[rfl_id].slot[s].acc;
                    s_d.fd[s]                        = rfl_data;
                    s_d.ent[rfl_id].slot[s].valid    = 1'b0;
                end
            end
            if (rfl_last) begin
                s_d.flv         = 1'b1;
                s_d.flb         = s_q.ent[rfl_id].blk;
                s_d.fld         = s_d.ent[rfl_id].data;
                s_d.flp         = s_q.ent[rfl_id].pref;
                s_d.ent[rfl_id] = '0;
            end
        end

        if (take && hit_any && !req_pref) begin
            s_d.ent[hit_id].pref = 1'b0;
            if (served) begin
                s_d.fv[SLOT_N] = 1'b1;
                s_d.fi[SLOT_N] = acc;
                s_d.fd[SLOT_N] = s_q.ent[hit_id].arrived[req_sub] ?
                                 s_q.ent[hit_id].data[req_sub] : rfl_data;
            end else begin
                s_d.ent[hit_id].slot[slot_id].valid = 1'b1;
                s_d.ent[hit_id].slot[slot_id].acc   = acc;
            end
        end

        if (take && !hit_any) begin
            s_d.ent[free_id]        = '0;
            s_d.ent[free_id].valid  = 1'b1;
            s_d.ent[free_id].blk    = req_blk;
            s_d.ent[free_id].pref   = req_pref;
            s_d.ent[free_id].issued = 1'b1;
            if (!req_pref) begin
                s_d.ent[free_id].slot[0].valid = 1'b1;
                s_d.ent[free_id].slot[0].acc   = acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fwd_valid  = s_q.fv;
    assign fwd_info   = s_q.fi;
    assign fwd_data   = s_q.fd;
    assign fill_valid = s_q.flv;
    assign fill_blk   = s_q.flb;
    assign fill_data  = s_q.fld;
    assign fill_pref  = s_q.flp;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk
    import mshr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_stall,
    input logic              mem_req_valid,
    input logic              rfl_valid,
    input logic [LANE_N-1:0] fwd_valid,
    input logic              fill_valid
);
    // R2
    mem_req_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (req_valid && !req_stall));

    // R4
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_stall |-> (req_valid && !mem_req_valid));

    // R5
    lane_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fwd_valid[SLOT_N-1:0]) |-> $past(rfl_valid));

    // R6
    fill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(rfl_valid));

    // R7
    direct_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid[SLOT_N] |-> $past(req_valid && !req_stall));
endmodule

bind mshr_file mshr_file_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_stall    (req_stall),
    .mem_req_valid(mem_req_valid),
    .rfl_valid    (rfl_valid),
    .fwd_valid    (fwd_valid),
    .fill_valid   (fill_valid)
);

// File: tb/mshr_file_test.sv
module mshr_file_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [27:0]  req_blk = '0;
    logic         req_pref = 1'b0;
    logic         req_store = 1'b0;
    logic [1:0]   req_size = '0;
    logic [3:0]   req_off = '0;
    logic [5:0]   req_dest = '0;
    logic         req_stall;
    logic         mem_req_valid;
    logic [27:0]  mem_req_blk;
    logic [1:0]   mem_req_id;
    logic         rfl_valid = 1'b0;
    logic [1:0]   rfl_id = '0;
    logic [1:0]   rfl_sub = '0;
    logic [31:0]  rfl_data = '0;
    logic [4:0]   fwd_valid;
    logic [64:0]  fwd_info;
    logic [159:0] fwd_data;
    logic         fill_valid;
    logic [27:0]  fill_blk;
    logic [127:0] fill_data;
    logic         fill_pref;

    int nchk = 0;
    int nfail = 0;
    logic        c_stall, c_mreq;
    logic [1:0]  c_mid;
    logic [27:0] c_mblk;

    localparam logic [27:0] BASE = 28'h0ABC000;
    localparam logic [27:0] PF_A = 28'h0F00001;
    localparam logic [27:0] PF_B = 28'h0F00002;

    always #10 clk = ~clk;

    mshr_file uut (.*);

    function automatic logic [31:0] bd(input int e, input int s);
        return 32'hC0DE_0000 + 32'(e * 16 + s);
    endfunction

    function automatic logic [12:0] inf(input bit st, input logic [3:0] off, input logic [5:0] d);
        return {st, d[1:0], off, d};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input bit rq, input logic [27:0] b, input bit pf, input bit st,
                      input logic [3:0] off, input logic [5:0] d,
                      input bit rf, input int id, input int sb, input logic [31:0] dat);
        req_valid = rq; req_blk = b; req_pref = pf; req_store = st;
        req_off = off; req_dest = d; req_size = d[1:0];
        rfl_valid = rf; rfl_id = 2'(id); rfl_sub = 2'(sb); rfl_data = dat;
        #1;
        c_stall = req_stall; c_mreq = mem_req_valid; c_mid = mem_req_id; c_mblk = mem_req_blk;
        @(negedge clk);
        req_valid = 1'b0;
        rfl_valid = 1'b0;
    endtask

    task automatic rq(input logic [27:0] b, input bit pf, input bit st,
                      input logic [3:0] off, input logic [5:0] d);
        op(1'b1, b, pf, st, off, d, 1'b0, 0, 0, '0);
    endtask

    task automatic rf(input int id, input int sb);
        op(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, id, sb, bd(id, sb));
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 fwd_valid", 128'(fwd_valid), 0);
        chk("R1 fill_valid", 128'(fill_valid), 0);
        chk("R1 req_stall", 128'(req_stall), 0);
        chk("R1 mem_req_valid", 128'(mem_req_valid), 0);
        @(negedge clk);

        // R2: claim entries 0..3, entry e waits on sub-block e
        for (int e = 0; e < 4; e++) begin
            rq(BASE + 28'(e), 1'b0, 1'b0, 4'(e << 2), 6'(e));
            chk("R2 no stall", 128'(c_stall), 0);
            chk("R2 mem_req_valid", 128'(c_mreq), 1);
            chk("R2 mem_req_id", 128'(c_mid), 128'(e));
            chk("R2 mem_req_blk", 128'(c_mblk), 128'(BASE + 28'(e)));
        end
        // R4: all entries live
        rq(BASE + 28'd9, 1'b0, 1'b0, 4'd0, 6'd5);
        chk("R4 stall on full entries", 128'(c_stall), 1);
        chk("R4 no mem_req", 128'(c_mreq), 0);

        // R3: merge three waiters into entry 1
        rq(BASE + 28'd1, 1'b0, 1'b1, 4'd8, 6'd10);
        chk("R3 merge no stall", 128'(c_stall), 0);
        chk("R3 merge no mem_req", 128'(c_mreq), 0);
        rq(BASE + 28'd1, 1'b0, 1'b0, 4'd9, 6'd11);
        chk("R3 merge no stall", 128'(c_stall), 0);
        rq(BASE + 28'd1, 1'b0, 1'b0, 4'd5, 6'd12);
        chk("R3 merge no mem_req", 128'(c_mreq), 0);
        // R4: waiter places full
        rq(BASE + 28'd1, 1'b0, 1'b0, 4'd0, 6'd13);
        chk("R4 stall on full slots", 128'(c_stall), 1);
        chk("R4 no mem_req slots", 128'(c_mreq), 0);

        // R5 / R11: beat sub 2 to entry 1 -> lanes 1 and 2
        rf(1, 2);
        chk("R5 lanes sub2", 128'(fwd_valid), 128'(5'b00110));
        chk("R5 lane1 info", 128'(fwd_info[13 +: 13]), 128'(inf(1'b1, 4'd8, 6'd10)));
        chk("R5 lane1 data", 128'(fwd_data[32 +: 32]), 128'(bd(1, 2)));
        chk("R5 lane2 info", 128'(fwd_info[26 +: 13]), 128'(inf(1'b0, 4'd9, 6'd11)));
        chk("R5 lane2 data", 128'(fwd_data[64 +: 32]), 128'(bd(1, 2)));
        chk("R5 no fill", 128'(fill_valid), 0);

        // R7: sub 2 now buffered
        rq(BASE + 28'd1, 1'b0, 1'b0, 4'd10, 6'd20);
        chk("R7 no stall", 128'(c_stall), 0);
        chk("R7 lane4 only", 128'(fwd_valid), 128'(5'b10000));
        chk("R7 lane4 data", 128'(fwd_data[128 +: 32]), 128'(bd(1, 2)));
        chk("R7 lane4 info", 128'(fwd_info[52 +: 13]), 128'(inf(1'b0, 4'd10, 6'd20)));

        // R11: new waiter takes place 1 (lowest free)
        rq(BASE + 28'd1, 1'b0, 1'b0, 4'd12, 6'd21);
        chk("R11 merge ok", 128'(c_stall), 0);

        // R8: beat sub 1 and request for sub 1 together
        op(1'b1, BASE + 28'd1, 1'b0, 1'b0, 4'd6, 6'd22, 1'b1, 1, 1, bd(1, 1));
        chk("R8 no stall", 128'(c_stall), 0);
        chk("R8 lanes", 128'(fwd_valid), 128'(5'b11001));
        chk("R8 lane4 data", 128'(fwd_data[128 +: 32]), 128'(bd(1, 1)));
        chk("R8 lane4 info", 128'(fwd_info[52 +: 13]), 128'(inf(1'b0, 4'd6, 6'd22)));
        chk("R5 lane3 info", 128'(fwd_info[39 +: 13]), 128'(inf(1'b0, 4'd5, 6'd12)));

        rf(1, 0);
        chk("R5 no waiters sub0", 128'(fwd_valid), 0);
        chk("R6 not yet complete", 128'(fill_valid), 0);

        // R9: final beat with a matching request
        op(1'b1, BASE + 28'd1, 1'b0, 1'b0, 4'd12, 6'd23, 1'b1, 1, 3, bd(1, 3));
        chk("R9 stall on closing entry", 128'(c_stall), 1);
        chk("R9 no mem_req", 128'(c_mreq), 0);
        chk("R11 lane1 sub3", 128'(fwd_valid), 128'(5'b00010));
        chk("R11 lane1 dest", 128'(fwd_info[13 +: 13]), 128'(inf(1'b0, 4'd12, 6'd21)));
        chk("R6 fill_valid", 128'(fill_valid), 1);
        chk("R6 fill_blk", 128'(fill_blk), 128'(BASE + 28'd1));
        chk("R6 fill_data", fill_data, {bd(1, 3), bd(1, 2), bd(1, 1), bd(1, 0)});
        chk("R6 fill_pref", 128'(fill_pref), 0);

        // R6 / R2: freed entry 1 is claimed again
        rq(BASE + 28'd1, 1'b0, 1'b0, 4'd4, 6'd1);
        chk("R6 reclaim mem_req", 128'(c_mreq), 1);
        chk("R2 reclaim lowest free", 128'(c_mid), 1);

        // R5 / R6 sweep: drain every entry, sub-blocks in reverse order
        for (int e = 0; e < 4; e++) begin
            for (int k = 0; k < 4; k++) begin
                logic [127:0] line;
                int s;
                s = 3 - k;
                rf(e, s);
                chk("R5 sweep lanes", 128'(fwd_valid), (s == e) ? 128'(5'b00001) : 128'(0));
                if (s == e) chk("R5 sweep data", 128'(fwd_data[31:0]), 128'(bd(e, s)));
                if (k == 3) begin
                    for (int j = 0; j < 4; j++) line[j*32 +: 32] = bd(e, j);
                    chk("R6 sweep fill", 128'(fill_valid), 1);
                    chk("R6 sweep blk", 128'(fill_blk), 128'(BASE + 28'(e)));
                    chk("R6 sweep data", fill_data, line);
                end else begin
                    chk("R6 sweep no fill", 128'(fill_valid), 0);
                end
            end
        end

        // R10 prefetch handling
        rq(PF_A, 1'b1, 1'b0, 4'd0, 6'd0);
        chk("R10 pref claims", 128'(c_mreq), 1);
        chk("R10 pref id", 128'(c_mid), 0);
        rq(PF_A, 1'b0, 1'b0, 4'd8, 6'd30);
        chk("R10 demand merge", 128'(c_mreq), 0);
        rq(PF_B, 1'b1, 1'b0, 4'd0, 6'd0);
        chk("R10 second pref id", 128'(c_mid), 1);
        rq(PF_B, 1'b1, 1'b0, 4'd0, 6'd0);
        chk("R10 pref absorbed", 128'(c_stall), 0);
        chk("R10 pref absorbed no req", 128'(c_mreq), 0);
        for (int s = 0; s < 4; s++) begin
            rf(1, s);
            chk("R10 pref no lanes", 128'(fwd_valid), 0);
        end
        chk("R10 pref fill flag", 128'(fill_pref), 1);
        chk("R10 pref fill valid", 128'(fill_valid), 1);
        for (int s = 0; s < 4; s++) begin
            rf(0, s);
            chk("R10 demand lane", 128'(fwd_valid), (s == 2) ? 128'(5'b00001) : 128'(0));
        end
        chk("R10 flag cleared", 128'(fill_pref), 0);
        chk("R10 fill blk", 128'(fill_blk), 128'(PF_A));

        summary();
    end
endmodule